// File: doc/BRIEF.md
# Programmable Down-Counting Timer with APB Access

This block is a bank of independent down-counters reached through an APB slave port. The number of channels is a parameter, and the default is two. Software programs each channel with a reload value and a control word. It can read the live count at any time. Because the counter runs downward, software inverts the count when it wants an up-count. Each channel raises its own interrupt line when its count expires. The interrupt stays pending until software reads a clear register. A per-channel mask bit can hide the interrupt without losing the pending state.

There are two counting modes. In user-defined (periodic) mode, the channel reloads its programmed value after passing zero, so it makes a repeating tick. In free-running mode, the channel always wraps to all ones, which suits a long-period time base. A set of shared registers gathers the masked and unmasked pending bits of every channel. They also give one read that clears every channel, and a fixed version word. The timer clock is the bus clock.

Top module: `apb_dtimer`

## Requirements
- R1: After reset, every channel's load, current-value and control registers read 0, the combined raw status reads 0, all interrupt outputs are low, PREADY is 1 and PSLVERR is 0.
- R2: Control bit 0 is the enable and bit 1 selects the mode (1 = periodic, 0 = free-running). One clock after enable goes from 0 to 1, the current value becomes the load value in periodic mode, or 0xFFFFFFFF in free-running mode.
- R3: While enabled and nonzero, the current value decreases by exactly one per clock.
- R4: In periodic mode, a count of zero is followed by the load value, so a load of L repeats every L+1 clocks.
- R5: In free-running mode, a count of zero is followed by 0xFFFFFFFF, and the load value is not used.
- R6: An enabled channel whose count is zero sets its raw pending bit on the next clock. The bit stays set until it is cleared.
- R7: A read of a channel's clear register (channel offset 0x0C) returns 0 and clears only that channel's pending bit. If an expiry happens in the same clock as the clear, the bit stays set.
- R8: A read of the shared clear register at 0xA4 returns 0 and clears the pending bits of all channels.
- R9: Control bit 2 is a mask. The channel status register (offset 0x10), bit i of the combined masked status at 0xA0, and interrupt output i all equal raw AND NOT mask. The combined raw status at 0xA8 ignores the mask.
- R10: While enable is 0, the count holds its value and no new pending bit is set.
- R11: Writing the load register (channel offset 0x00) while disabled leaves the current value unchanged. The new value appears in the count on the next enable.
- R12: Channel n occupies the base n*0x14, with its current value at offset 0x04 and its control at offset 0x08. The version word reads 0x00010003 at 0xAC. Writes to read-only or unmapped addresses change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | N_CH (2) | Masked interrupt, one per channel |

## Verification
On every cycle, the in-RTL properties check the counter: the start value on the enable edge, the step of one, the reload target in each mode, the hold while disabled, the sticky pending bit, clear priority, the mask gating of the interrupt, and the zero data returned by clear reads. The full free-running wrap from zero back to all ones needs 2^32 clocks, so only the properties show it. The bench shows what needs a sequence of bus accesses. That includes the exact count sampled k cycles after enable in both modes and on both channels, and clearing one channel while leaving the other pending. It also covers the masked and raw views disagreeing, load writes while disabled, and writes to read-only and unmapped addresses being ignored.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

   // register offsets inside one channel window
   localparam int OFS_LOAD  = 'h00;
   localparam int OFS_CUR   = 'h04;
   localparam int OFS_CTRL  = 'h08;
   localparam int OFS_CLR   = 'h0C;
   localparam int OFS_STAT  = 'h10;
   localparam int CH_STRIDE = 'h14;

   // shared registers
   localparam int SH_MSTAT  = 'hA0;
   localparam int SH_CLRALL = 'hA4;
   localparam int SH_RSTAT  = 'hA8;
   localparam int SH_VER    = 'hAC;

   typedef struct packed {
      logic mask;      // bit 2
      logic periodic;  // bit 1
      logic en;        // bit 0
   } dt_ctrl_t;

endpackage

// File: rtl/dtimer_chan.sv
module dtimer_chan
   import dtimer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_load,
   input  logic             wr_ctrl,
   input  logic [CNT_W-1:0] wdata,
   input  dt_ctrl_t         wctrl,
   input  logic             clear,
   output logic [CNT_W-1:0] load_q,
   output logic [CNT_W-1:0] count_q,
   output dt_ctrl_t         ctrl_q,
   output logic             raw_q,
   output logic             irq
);

   logic             en_q;
   logic             start;
   logic             running;
   logic             expire;
   logic [CNT_W-1:0] reload_val;

   assign start      = ctrl_q.en & ~en_q;
   assign running    = ctrl_q.en & en_q;
   assign expire     = running & (count_q == '0);
   assign reload_val = ctrl_q.periodic ? load_q : {CNT_W{1'b1}};
   assign irq        = raw_q & ~ctrl_q.mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         load_q  <= '0;
         count_q <= '0;
         ctrl_q  <= '0;
         raw_q   <= 1'b0;
      end else begin
         en_q <= ctrl_q.en;
         if (wr_load) load_q <= wdata;
         if (wr_ctrl) ctrl_q <= wctrl;
         if (start) begin
            count_q <= reload_val;
         end else if (running) begin
            if (count_q == '0) count_q <= reload_val;
            else               count_q <= count_q - 1'b1;
         end
         if (expire)     raw_q <= 1'b1;
         else if (clear) raw_q <= 1'b0;
      end
   end

   p_start_per_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ctrl_q.periodic) |=> (count_q == $past(load_q)));
   p_start_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ctrl_q.periodic) |=> (&count_q));
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q.periodic) |=> (count_q == $past(load_q)));
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl_q.periodic) |=> (&count_q));
   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw_q);
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q && !clear) |=> raw_q);
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !expire) |=> !raw_q);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |=> $stable(count_q));
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && !raw_q) |=> !raw_q);

endmodule

// File: rtl/dtimer_regs.sv
module dtimer_regs
   import dtimer_pkg::*;
#(
   parameter int          N_CH    = 2,
   parameter int          CNT_W   = 32,
   parameter int          ADDR_W  = 8,
   parameter int          DATA_W  = 32,
   parameter logic [31:0] VERSION = 32'h0001_0003
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [N_CH-1:0][CNT_W-1:0]  ch_load,
   input  logic [N_CH-1:0][CNT_W-1:0]  ch_count,
   input  dt_ctrl_t [N_CH-1:0]         ch_ctrl,
   input  logic [N_CH-1:0]             ch_raw,
   output logic [N_CH-1:0]             wr_load,
   output logic [N_CH-1:0]             wr_ctrl,
   output logic [N_CH-1:0]             rd_clr,
   output logic                        clr_all,
   output logic [DATA_W-1:0]           rdata
);

   function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int ofs);
      return ADDR_W'(ch * CH_STRIDE + ofs);
   endfunction

   localparam logic [ADDR_W-1:0] A_MSTAT  = ADDR_W'(SH_MSTAT);
   localparam logic [ADDR_W-1:0] A_CLRALL = ADDR_W'(SH_CLRALL);
   localparam logic [ADDR_W-1:0] A_RSTAT  = ADDR_W'(SH_RSTAT);
   localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(SH_VER);

   logic [N_CH-1:0] masked;

   for (genvar i = 0; i < N_CH; i++) begin : g_strobe
      assign wr_load[i] = wr_en & (addr == ch_addr(i, OFS_LOAD));
      assign wr_ctrl[i] = wr_en & (addr == ch_addr(i, OFS_CTRL));
      assign rd_clr[i]  = rd_en & (addr == ch_addr(i, OFS_CLR));
      assign masked[i]  = ch_raw[i] & ~ch_ctrl[i].mask;
   end
   assign clr_all = rd_en & (addr == A_CLRALL);

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (addr == ch_addr(i, OFS_LOAD)) rdata = DATA_W'(ch_load[i]);
         if (addr == ch_addr(i, OFS_CUR))  rdata = DATA_W'(ch_count[i]);
         if (addr == ch_addr(i, OFS_CTRL)) rdata = DATA_W'(ch_ctrl[i]);
         if (addr == ch_addr(i, OFS_STAT)) rdata = DATA_W'(masked[i]);
      end
      if (addr == A_MSTAT) rdata = DATA_W'(masked);
      if (addr == A_RSTAT) rdata = DATA_W'(ch_raw);
      if (addr == A_VER)   rdata = DATA_W'(VERSION);
   end

   p_clr_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_clr || clr_all) |-> (rdata == '0));
   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_load, wr_ctrl}));

endmodule

// File: rtl/apb_dtimer.sv
module apb_dtimer
   import dtimer_pkg::*;
#(
   parameter int          N_CH    = 2,
   parameter int          CNT_W   = 32,
   parameter int          ADDR_W  = 8,
   parameter int          DATA_W  = 32,
   parameter logic [31:0] VERSION = 32'h0001_0003
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [N_CH-1:0]   irq
);

   localparam int MAX_CH = SH_MSTAT / CH_STRIDE;

   if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_nch
      $error("apb_dtimer: N_CH out of range");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cntw
      $error("apb_dtimer: CNT_W must fit in DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addrw
      $error("apb_dtimer: ADDR_W too small for the shared registers");
   end
   if (DATA_W < 32) begin : g_bad_dataw
      $error("apb_dtimer: DATA_W must hold the version word");
   end

   logic                       wr_en;
   logic                       rd_en;
   logic [N_CH-1:0][CNT_W-1:0] ch_load;
   logic [N_CH-1:0][CNT_W-1:0] ch_count;
   dt_ctrl_t [N_CH-1:0]        ch_ctrl;
   logic [N_CH-1:0]            ch_raw;
   logic [N_CH-1:0]            wr_load;
   logic [N_CH-1:0]            wr_ctrl;
   logic [N_CH-1:0]            rd_clr;
   logic                       clr_all;

   assign wr_en   = psel & penable & pwrite;
   assign rd_en   = psel & penable & ~pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   dtimer_regs #(
      .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .VERSION(VERSION)
   ) u_regs (
      .clk(pclk), .rst_n(presetn), .addr(paddr), .wr_en(wr_en), .rd_en(rd_en),
      .ch_load(ch_load), .ch_count(ch_count), .ch_ctrl(ch_ctrl), .ch_raw(ch_raw),
      .wr_load(wr_load), .wr_ctrl(wr_ctrl), .rd_clr(rd_clr), .clr_all(clr_all),
      .rdata(prdata)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      dtimer_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(pclk), .rst_n(presetn),
         .wr_load(wr_load[i]), .wr_ctrl(wr_ctrl[i]),
         .wdata(pwdata[CNT_W-1:0]), .wctrl(dt_ctrl_t'(pwdata[2:0])),
         .clear(rd_clr[i] | clr_all),
         .load_q(ch_load[i]), .count_q(ch_count[i]), .ctrl_q(ch_ctrl[i]),
         .raw_q(ch_raw[i]), .irq(irq[i])
      );

      p_mask_r9: assert property (@(posedge pclk) disable iff (!presetn)
         ch_ctrl[i].mask |-> !irq[i]);
      p_irq_raw_r9: assert property (@(posedge pclk) disable iff (!presetn)
         irq[i] |-> ch_raw[i]);
   end

endmodule

// File: tb/apb_dtimer_tb.sv
module apb_dtimer_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] VER_EXP = 32'h0001_0003;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic [1:0]  irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) pclk = ~pclk;

   apb_dtimer u_dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .irq(irq)
   );

   typedef struct packed {
      logic [7:0]  base;
      logic        periodic;
      logic [31:0] load;
      logic [7:0]  wait_n;
      logic [31:0] expv;
   } vec_t;

   // count seen k cycles after the enable write: periodic L - (k mod (L+1)), free all-ones - k
   localparam vec_t VECS [9] = '{
      '{8'h00, 1'b1, 32'd5,   8'd0,  32'd5},
      '{8'h00, 1'b1, 32'd5,   8'd3,  32'd2},
      '{8'h00, 1'b1, 32'd5,   8'd5,  32'd0},
      '{8'h00, 1'b1, 32'd5,   8'd6,  32'd5},
      '{8'h14, 1'b1, 32'd5,   8'd8,  32'd3},
      '{8'h14, 1'b1, 32'd0,   8'd4,  32'd0},
      '{8'h00, 1'b0, 32'd77,  8'd0,  32'hFFFF_FFFF},
      '{8'h14, 1'b0, 32'd77,  8'd10, 32'hFFFF_FFF5},
      '{8'h14, 1'b1, 32'd200, 8'd13, 32'd187}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
      end
   endtask

   task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] expv);
      logic [31:0] d;
      apb_rd(a, d);
      check(req, d, expv);
   endtask

   initial begin
      repeat (200000) @(posedge pclk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v1, v2;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      @(negedge pclk);

      // R1 reset state
      check("R1 irq", {30'd0, irq}, 32'd0);
      check("R1 pready", {31'd0, pready}, 32'd1);
      check("R1 pslverr", {31'd0, pslverr}, 32'd0);
      rd_check("R1 load", 8'h00, 32'd0);
      rd_check("R1 current", 8'h04, 32'd0);
      rd_check("R1 ctrl", 8'h08, 32'd0);
      rd_check("R1 ch1 ctrl", 8'h1C, 32'd0);
      rd_check("R1 raw", 8'hA8, 32'd0);

      // R2 R3 R4 R5 table walk
      foreach (VECS[i]) begin
         apb_wr(VECS[i].base + 8'h08, 32'd0);
         apb_wr(VECS[i].base + 8'h00, VECS[i].load);
         apb_wr(VECS[i].base + 8'h08, {29'd0, 1'b1, VECS[i].periodic, 1'b1});
         repeat (int'(VECS[i].wait_n)) @(negedge pclk);
         apb_rd(VECS[i].base + 8'h04, v1);
         check($sformatf("R2/R3/R4/R5 row %0d", i), v1, VECS[i].expv);
      end

      // R8 global clear after stopping both channels
      apb_wr(8'h08, 32'd0);
      apb_wr(8'h1C, 32'd0);
      rd_check("R8 clear-all reads 0", 8'hA4, 32'd0);
      rd_check("R8 raw after clear-all", 8'hA8, 32'd0);

      // R6 R9 R10 R7 on channel 0
      apb_wr(8'h00, 32'd3);
      apb_wr(8'h08, 32'd3);
      repeat (10) @(negedge pclk);
      check("R6 irq after expiry", {30'd0, irq}, 32'd1);
      apb_wr(8'h08, 32'd0);
      apb_rd(8'h04, v1);
      repeat (5) @(negedge pclk);
      apb_rd(8'h04, v2);
      check("R10 count held", v2, v1);
      check("R6 sticky irq", {30'd0, irq}, 32'd1);
      rd_check("R9 ch status", 8'h10, 32'd1);
      rd_check("R9 masked combined", 8'hA0, 32'd1);
      apb_wr(8'h08, 32'd4);
      check("R9 masked irq", {30'd0, irq}, 32'd0);
      rd_check("R9 ch status masked", 8'h10, 32'd0);
      rd_check("R9 combined masked", 8'hA0, 32'd0);
      rd_check("R9 raw ignores mask", 8'hA8, 32'd1);
      rd_check("R12 ctrl readback", 8'h08, 32'd4);
      rd_check("R7 clear reads 0", 8'h0C, 32'd0);
      rd_check("R7 raw cleared", 8'hA8, 32'd0);
      apb_wr(8'h08, 32'd0);
      repeat (20) @(negedge pclk);
      rd_check("R10 no new pending", 8'hA8, 32'd0);

      // R7 per-channel clear, R8 clear all
      apb_wr(8'h00, 32'd2);
      apb_wr(8'h14, 32'd2);
      apb_wr(8'h08, 32'd3);
      apb_wr(8'h1C, 32'd3);
      repeat (10) @(negedge pclk);
      apb_wr(8'h08, 32'd0);
      apb_wr(8'h1C, 32'd0);
      check("R6 both pending", {30'd0, irq}, 32'd3);
      rd_check("R7 ch1 clear reads 0", 8'h20, 32'd0);
      check("R7 only ch1 cleared", {30'd0, irq}, 32'd1);
      rd_check("R8 clear-all reads 0", 8'hA4, 32'd0);
      check("R8 all cleared", {30'd0, irq}, 32'd0);

      // R7 expiry wins over a same-cycle clear (load 0 expires every cycle)
      apb_wr(8'h00, 32'd0);
      apb_wr(8'h08, 32'd3);
      repeat (3) @(negedge pclk);
      apb_rd(8'h0C, v1);
      check("R7 expiry beats clear", {30'd0, irq}, 32'd1);
      apb_wr(8'h08, 32'd0);
      apb_rd(8'hA4, v1);

      // R11 load write while disabled
      apb_rd(8'h18, v1);
      apb_wr(8'h14, 32'd40);
      apb_rd(8'h18, v2);
      check("R11 count unchanged by load write", v2, v1);
      rd_check("R11 load readback", 8'h14, 32'd40);
      apb_wr(8'h1C, 32'd3);
      rd_check("R11 new load on enable", 8'h18, 32'd40);
      apb_wr(8'h1C, 32'd0);

      // R12 map, read-only and unmapped addresses
      rd_check("R12 version", 8'hAC, VER_EXP);
      apb_wr(8'hAC, 32'h0);
      rd_check("R12 version read-only", 8'hAC, VER_EXP);
      apb_wr(8'hA8, 32'hFF);
      rd_check("R12 raw read-only", 8'hA8, 32'd0);
      apb_wr(8'h30, 32'hDEAD_BEEF);
      rd_check("R12 unmapped reads 0", 8'h30, 32'd0);
      rd_check("R12 unmapped 0x9C", 8'h9C, 32'd0);
      apb_rd(8'h04, v1);
      apb_wr(8'h04, 32'h1234);
      rd_check("R12 current read-only", 8'h04, v1);
      check("R12 pready", {31'd0, pready}, 32'd1);
      check("R12 pslverr", {31'd0, pslverr}, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule